// File: doc/BRIEF.md
# Two-Channel Conversion Sequencer and Result Formatter

This block holds the settings that steer a two-input sampling front end. Two kinds of write reach it, already decoded: a control write that carries output coding, a channel address, two sequence bits and two input-pairing bits, and a range write that carries one span code for each channel. From these it chooses the channel for the next conversion. It also presents the pairing mode, that channel's span code and the active output coding. It reformats the converter's raw sign-plus-12-bit two's complement result into the selected coding.

Writes go into a pending copy of the settings. A one-cycle frame-done pulse marks the end of each conversion frame, and the pending copy becomes active on that pulse. Settings written during a frame therefore apply to the next conversion and never to the one in progress. Between pulses, every selection output holds its value. When the sequence bits select alternation, the channel toggles on every frame, and a fresh control write restarts the pattern at channel 0.

Top module: `seq2_cfg_top`

## Requirements
- R1: After reset, next_chan is 0, pair_mode is 00 (two single-ended inputs), range_code is 00 (±10 V), coding_sb is 0 (two's complement) and mode_err is 0.
- R2: Control and range writes change no output until the next frame_done pulse. A change in wr_data while both write strobes are low has no effect. All selection outputs are held constant in every cycle that follows a cycle without frame_done.
- R3: Control write layout: bit 0 is coding, bit 1 is the channel address, bits 3:2 are the sequence bits and bits 5:4 are the pairing mode. Except for sequence 10 with address 1, next_chan after a frame equals the committed address bit.
- R4: Sequence bits 10 with address 1 make next_chan 0 on the first frame after the control write, and make it toggle on every later frame. Any new control write restarts the pattern at channel 0 on the following frame.
- R5: Range write layout: bits 1:0 are the channel 0 span and bits 3:2 are the channel 1 span. The codes are 00 ±10 V, 01 ±5 V, 10 ±2.5 V and 11 0 to 10 V. range_code shows the field of the channel on next_chan.
- R6: With coding_sb 0, fmt_word equals raw_result. With coding_sb 1, fmt_word is raw_result with bit 12 inverted (straight binary).
- R7: Pairing codes are 00 single-ended, 01 fully differential and 10 pseudo-differential. A control write carrying code 11 leaves the pending mode unchanged and sets mode_err, which stays set until reset. The other fields of that write still take effect.
- R8: A write in the same cycle as frame_done is included in the settings committed by that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control write strobe |
| range_wr | input | 1 | Range write strobe |
| wr_data | input | 12 | Write payload |
| frame_done | input | 1 | One-cycle end-of-frame pulse |
| raw_result | input | 13 | Raw two's complement sign-plus-12-bit result |
| next_chan | output | 1 | Channel for the next conversion |
| pair_mode | output | 2 | Active input-pairing mode |
| range_code | output | 2 | Span code of the selected channel |
| coding_sb | output | 1 | Active coding, 1 = straight binary |
| fmt_word | output | 13 | Result in the active coding |
| mode_err | output | 1 | Sticky reserved-mode flag |

## Verification
The hardest case to reach is how alternation interacts with rewrites. Telling a continuing toggle from a restart requires a control write between two frames that carries exactly the same alternating value. The same check is needed when that write lands in the very cycle of frame_done. The stimulus runs long alternating stretches and rewrites the identical word, both mid-frame and coincident with the pulse. A bench model of the pending and active settings predicts whether channel 0 or the toggled channel follows.

// File: rtl/seq2_cfg_pkg.sv
// Shared field positions and codes for the two-channel sequencer.
// Assumes a fixed two-channel arrangement (one-bit channel index).
package seq2_cfg_pkg;
    localparam int CODING_BIT = 0;
    localparam int ADDR_BIT   = 1;
    localparam int SEQ_LSB    = 2;
    localparam int MODE_LSB   = 4;
    localparam int NCH        = 2;

    localparam logic [1:0] SEQ_ALT = 2'b10;

    localparam logic [1:0] PAIR_SINGLE = 2'b00;
    localparam logic [1:0] PAIR_DIFF   = 2'b01;
    localparam logic [1:0] PAIR_PSEUDO = 2'b10;
    localparam logic [1:0] PAIR_RSVD   = 2'b11;
endpackage

// File: rtl/seq2_cfg_shadow.sv
// Pending settings: takes decoded writes and offers the merged next value
// (pending plus any same-cycle write) to the commit stage.
// Assumes writes and frame_done are synchronous single-cycle strobes.
module seq2_cfg_shadow
    import seq2_cfg_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int RNG_W  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctrl_wr,
    input  logic                   range_wr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   frame_done,
    output logic                   coding_nx,
    output logic                   addr_nx,
    output logic [1:0]             seq_nx,
    output logic [1:0]             mode_nx,
    output logic [NCH*RNG_W-1:0]   rng_nx,
    output logic                   cw_nx,
    output logic                   mode_err
);
    localparam int RNG_TOT = NCH * RNG_W;

    logic               coding_q, addr_q, cw_q, err_q;
    logic [1:0]         seq_q, mode_q;
    logic [RNG_TOT-1:0] rng_q;
    logic               rsvd_wr;

    assign rsvd_wr = ctrl_wr && (wr_data[MODE_LSB +: 2] == PAIR_RSVD);

    // Merge a control write into the pending control fields.
    always_comb begin
        coding_nx = coding_q;
        addr_nx   = addr_q;
        seq_nx    = seq_q;
        mode_nx   = mode_q;
        cw_nx     = cw_q;
        if (ctrl_wr) begin
            coding_nx = wr_data[CODING_BIT];
            addr_nx   = wr_data[ADDR_BIT];
            seq_nx    = wr_data[SEQ_LSB +: 2];
            cw_nx     = 1'b1;
            if (!rsvd_wr) mode_nx = wr_data[MODE_LSB +: 2];
        end
    end

    // One range field per channel, each replaced by a range write.
    for (genvar c = 0; c < NCH; c++) begin : g_rng
        always_comb begin
            rng_nx[c*RNG_W +: RNG_W] = range_wr ? wr_data[c*RNG_W +: RNG_W]
                                                : rng_q[c*RNG_W +: RNG_W];
        end
    end

    // Hold pending settings; the rewrite marker clears when committed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coding_q <= 1'b0;
            addr_q   <= 1'b0;
            seq_q    <= 2'b00;
            mode_q   <= PAIR_SINGLE;
            rng_q    <= '0;
            cw_q     <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            coding_q <= coding_nx;
            addr_q   <= addr_nx;
            seq_q    <= seq_nx;
            mode_q   <= mode_nx;
            rng_q    <= rng_nx;
            cw_q     <= frame_done ? 1'b0 : cw_nx;
            err_q    <= err_q | rsvd_wr;
        end
    end

    assign mode_err = err_q;

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    p_mode_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != PAIR_RSVD);
endmodule

// File: rtl/seq2_chan_seq.sv
// Commit stage and channel sequencer: on frame_done the pending settings
// become active and the next channel is chosen (fixed or alternating).
// Assumes frame_done is a single-cycle pulse per conversion frame.
module seq2_chan_seq
    import seq2_cfg_pkg::*;
#(
    parameter int RNG_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_done,
    input  logic                   coding_nx,
    input  logic                   addr_nx,
    input  logic [1:0]             seq_nx,
    input  logic [1:0]             mode_nx,
    input  logic [NCH*RNG_W-1:0]   rng_nx,
    input  logic                   cw_nx,
    output logic                   next_chan,
    output logic [1:0]             pair_mode,
    output logic [RNG_W-1:0]       range_code,
    output logic                   coding
);
    logic                 chan_q, alt_q, coding_q;
    logic [1:0]           mode_q;
    logic [NCH*RNG_W-1:0] rng_q;
    logic                 alt_nx, cont_nx, chan_nx;

    // Decide the channel that the committed settings will select.
    always_comb begin
        alt_nx  = (seq_nx == SEQ_ALT) && addr_nx;
        cont_nx = alt_nx && alt_q && !cw_nx;
        if (!alt_nx)      chan_nx = addr_nx;
        else if (cont_nx) chan_nx = ~chan_q;
        else              chan_nx = 1'b0;
    end

    // Active settings, replaced only at the end of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q   <= 1'b0;
            alt_q    <= 1'b0;
            coding_q <= 1'b0;
            mode_q   <= PAIR_SINGLE;
            rng_q    <= '0;
        end else if (frame_done) begin
            chan_q   <= chan_nx;
            alt_q    <= alt_nx;
            coding_q <= coding_nx;
            mode_q   <= mode_nx;
            rng_q    <= rng_nx;
        end
    end

    assign next_chan  = chan_q;
    assign pair_mode  = mode_q;
    assign coding     = coding_q;
    assign range_code = rng_q[chan_q*RNG_W +: RNG_W];

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(next_chan) && $stable(pair_mode)
                        && $stable(range_code) && $stable(coding));
    p_fixed_chan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && !alt_nx |=> next_chan == $past(addr_nx));
    p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && cont_nx |=> next_chan != $past(next_chan));
    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && alt_nx && !cont_nx |=> next_chan == 1'b0);
endmodule

// File: rtl/seq2_result_fmt.sv
// Result formatter: passes the two's complement word through, or flips
// its sign bit for straight binary. Assumes raw input is sign-plus-magnitude
// bits in two's complement form.
module seq2_result_fmt #(
    parameter int RAW_W = 13
) (
    input  logic             coding,
    input  logic [RAW_W-1:0] raw,
    output logic [RAW_W-1:0] fmt
);
    // Offset-binary conversion by inverting the top bit.
    always_comb begin
        fmt = raw;
        if (coding) fmt[RAW_W-1] = ~raw[RAW_W-1];
    end
endmodule

// File: rtl/seq2_cfg_top.sv
// Top: pending settings, commit/sequencer and result formatter.
// Assumes one frame_done pulse per completed conversion frame.
module seq2_cfg_top #(
    parameter int DATA_W = 12,
    parameter int RNG_W  = 2,
    parameter int RAW_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              range_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_done,
    input  logic [RAW_W-1:0]  raw_result,
    output logic              next_chan,
    output logic [1:0]        pair_mode,
    output logic [RNG_W-1:0]  range_code,
    output logic              coding_sb,
    output logic [RAW_W-1:0]  fmt_word,
    output logic              mode_err
);
    localparam int RNG_TOT = seq2_cfg_pkg::NCH * RNG_W;

    logic               coding_nx, addr_nx, cw_nx;
    logic [1:0]         seq_nx, mode_nx;
    logic [RNG_TOT-1:0] rng_nx;

    seq2_cfg_shadow #(.DATA_W(DATA_W), .RNG_W(RNG_W)) shadow_i (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .range_wr(range_wr),
        .wr_data(wr_data), .frame_done(frame_done),
        .coding_nx(coding_nx), .addr_nx(addr_nx), .seq_nx(seq_nx),
        .mode_nx(mode_nx), .rng_nx(rng_nx), .cw_nx(cw_nx),
        .mode_err(mode_err)
    );

    seq2_chan_seq #(.RNG_W(RNG_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
        .coding_nx(coding_nx), .addr_nx(addr_nx), .seq_nx(seq_nx),
        .mode_nx(mode_nx), .rng_nx(rng_nx), .cw_nx(cw_nx),
        .next_chan(next_chan), .pair_mode(pair_mode),
        .range_code(range_code), .coding(coding_sb)
    );

    seq2_result_fmt #(.RAW_W(RAW_W)) fmt_i (
        .coding(coding_sb), .raw(raw_result), .fmt(fmt_word)
    );
endmodule

// File: tb/seq2_cfg_top_tb.sv
module seq2_cfg_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0, range_wr = 1'b0, frame_done = 1'b0;
    logic [11:0] wr_data = '0;
    logic [12:0] raw_result = '0;
    logic        next_chan, coding_sb, mode_err;
    logic [1:0]  pair_mode, range_code;
    logic [12:0] fmt_word;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model of pending and active settings
    bit       p_coding, p_addr, p_cw, e_err;
    bit [1:0] p_seq, p_mode, p_r0, p_r1;
    bit       a_chan, a_alt, a_coding;
    bit [1:0] a_mode, a_r0, a_r1;

    always #4 clk = ~clk;

    seq2_cfg_top dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .range_wr(range_wr),
        .wr_data(wr_data), .frame_done(frame_done), .raw_result(raw_result),
        .next_chan(next_chan), .pair_mode(pair_mode), .range_code(range_code),
        .coding_sb(coding_sb), .fmt_word(fmt_word), .mode_err(mode_err)
    );

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "next_chan",  next_chan,  a_chan);
        chk(req, "pair_mode",  pair_mode,  a_mode);
        chk(req, "range_code", range_code, a_chan ? a_r1 : a_r0);
        chk(req, "coding_sb",  coding_sb,  a_coding);
        chk(req, "mode_err",   mode_err,   e_err);
    endtask

    function automatic void m_ctrl(input bit [11:0] d);
        p_coding = d[0];
        p_addr   = d[1];
        p_seq    = d[3:2];
        if (d[5:4] == 2'b11) e_err = 1'b1;
        else                 p_mode = d[5:4];
        p_cw = 1'b1;
    endfunction

    function automatic void m_frame();
        bit alt;
        alt = (p_seq == 2'b10) && p_addr;
        if (!alt)                 a_chan = p_addr;
        else if (a_alt && !p_cw)  a_chan = ~a_chan;
        else                      a_chan = 1'b0;
        a_alt = alt; a_coding = p_coding; a_mode = p_mode;
        a_r0 = p_r0; a_r1 = p_r1; p_cw = 1'b0;
    endfunction

    task automatic ctrl_write(input bit [11:0] d);
        @(negedge clk); ctrl_wr = 1'b1; wr_data = d;
        @(negedge clk); ctrl_wr = 1'b0;
        m_ctrl(d);
    endtask

    task automatic range_write(input bit [11:0] d);
        @(negedge clk); range_wr = 1'b1; wr_data = d;
        @(negedge clk); range_wr = 1'b0;
        p_r0 = d[1:0]; p_r1 = d[3:2];
    endtask

    task automatic frame(input string req);
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        m_frame();
        chk_all(req);
    endtask

    // R8: control write coincident with frame_done
    task automatic ctrl_with_frame(input bit [11:0] d);
        @(negedge clk); ctrl_wr = 1'b1; frame_done = 1'b1; wr_data = d;
        @(negedge clk); ctrl_wr = 1'b0; frame_done = 1'b0;
        m_ctrl(d); m_frame();
        chk_all("R8");
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_all("R1");
        chk("R1", "fmt_word", fmt_word, raw_result);

        // R2: writes pend until a frame; idle data changes are ignored
        range_write(12'h00E);
        ctrl_write(12'h01B);
        repeat (3) @(negedge clk);
        chk_all("R2");
        frame("R2");
        wr_data = 12'hFFF;
        repeat (3) @(negedge clk);
        frame("R2");

        // R3: every non-alternating sequence/address pair
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 2; a++) begin
                if (s == 2 && a == 1) continue;
                ctrl_write(12'((s << 2) | (a << 1)));
                for (int f = 0; f < 3; f++) frame("R3");
            end

        // R4: alternation, rewrite restart mid-run
        ctrl_write(12'h00A);
        for (int f = 0; f < 5; f++) frame("R4");
        ctrl_write(12'h00A);
        for (int f = 0; f < 4; f++) frame("R4");
        ctrl_write(12'h002);
        frame("R4");

        // R5: all range pairs on each channel, fixed and alternating
        for (int r = 0; r < 16; r++)
            for (int a = 0; a < 2; a++) begin
                range_write(12'(r));
                ctrl_write(12'(a << 1));
                frame("R5");
            end
        range_write(12'h006);
        ctrl_write(12'h00A);
        for (int f = 0; f < 4; f++) frame("R5");

        // R7: all pairing codes, reserved keeps mode and sets sticky flag
        for (int m = 0; m < 4; m++) begin
            ctrl_write(12'(m << 4));
            frame("R7");
        end
        ctrl_write(12'h020);
        frame("R7");

        // R8: writes coincident with frame_done, incl. alternation restart
        ctrl_write(12'h00A);
        frame("R8");
        frame("R8");
        ctrl_with_frame(12'h00A);
        frame("R8");
        ctrl_with_frame(12'h013);
        ctrl_with_frame(12'h00B);
        frame("R8");

        // R6: full raw sweep in both codings
        for (int c = 0; c < 2; c++) begin
            ctrl_write(12'(c));
            frame("R6");
            for (int v = 0; v < 8192; v++) begin
                raw_result = 13'(v);
                #1;
                chk("R6", "fmt_word", fmt_word,
                    c ? (v ^ 32'h1000) : v);
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule